// File: doc/BRIEF.md
# Buffer Transfer Byte Counter and Address Pointer

This block counts and addresses the bytes of one data transfer between an external buffer memory and the host port. A control processor loads a byte count (two bytes) and a buffer start address (three write-only bytes), then writes a start register whose bit 0 selects the direction. From then on the engine reports busy. It advances the buffer address by one for every byte moved on the memory side. It decrements the count on the strobe that belongs to the chosen direction: host reads when data goes to the host, buffer writes when data comes from the host.

When the count steps from one to zero, busy drops and a single-cycle end event is raised for the interrupt logic. A start with a zero count raises the end event at once and never touches memory. The count is either a full 16 bits wide or, in the narrow mode, 15 bits wide. In the narrow mode, bit 7 of the high count byte reads back the external transfer-end interrupt flag in place of a count bit.

Memory timing and host bus decode are outside the block. Both arrive as single-cycle strobes.

Top module: `bufxfer_engine`

## Requirements
- R1: After reset, busy and xfer_end are 0, both count readback bytes are 0 and buf_addr is 0.
- R2: While idle, a CPU write at offset 0 or 1 loads the count low or high byte, and that byte reads back on cnt_rd_lo or cnt_rd_hi. Writes at offsets 2, 3 and 4 load buf_addr bits [7:0], [15:8] and [20:16]; only the five low data bits are used at offset 4.
- R3: With narrow_cnt=1, the count has 15 bits. Bit 7 of a high-byte write is discarded. cnt_rd_hi bit 7 shows xfer_end_irq, and a high byte of 0x80 with a low byte of 0 counts as zero.
- R4: With narrow_cnt=0, all 16 count bits are stored and read back, including bit 7 of the high byte.
- R5: While idle, a CPU write at offset 5 with a nonzero count sets busy on the next cycle. Bit 0 of the written data selects the direction: 1 means memory to host, 0 means host to memory.
- R6: In a memory-to-host transfer, each host_rd_stb decrements the count by one, and buf_stb does not change the count.
- R7: In a host-to-memory transfer, each buf_stb decrements the count by one, and host_rd_stb does not change the count.
- R8: While busy, each buf_stb increments buf_addr by one in either direction, whatever host_rd_stb does in that cycle.
- R9: In the cycle after the count is decremented from one to zero, busy is 0 and xfer_end is 1. xfer_end is 0 again one cycle later.
- R10: A start with a zero count gives xfer_end=1 for exactly one cycle, leaves busy at 0 and leaves buf_addr unchanged.
- R11: buf_addr wraps from 0x1FFFFF to 0x000000.
- R12: While busy, CPU writes to the count, address and start offsets have no effect. While idle, host_rd_stb and buf_stb change neither the count nor buf_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| narrow_cnt | input | 1 | 1 = 15-bit count with the interrupt flag in bit 15 of the readback |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_addr | input | 3 | CPU register offset |
| cpu_wdata | input | 8 | CPU write data |
| xfer_end_irq | input | 1 | Transfer-end interrupt state, shown in the high readback byte in narrow mode |
| host_rd_stb | input | 1 | One host read of a data byte |
| buf_stb | input | 1 | One byte moved on the buffer memory side |
| busy | output | 1 | Transfer in progress |
| xfer_end | output | 1 | One-cycle end-of-transfer event |
| buf_addr | output | 21 | Current buffer memory address |
| cnt_rd_lo | output | 8 | Count readback, low byte |
| cnt_rd_hi | output | 8 | Count readback, high byte |

## Verification
The address pointer and the byte counter are driven by different strobes. In a memory-to-host transfer, a host read and a buffer-side strobe can therefore arrive in the same cycle. The directed memory-to-host scenario raises both strobes together. It then expects the address to go up by exactly one and the count to go down by exactly one. The final decrement is also timed so that busy falls on the same edge the end event rises, and the bench checks that both show in the same sampled cycle.

// File: rtl/bxe_pkg.sv
// Package: shared widths and register offsets of the buffer transfer engine.
// Assumes byte-wide CPU writes and a count exactly two data bytes wide.
package bxe_pkg;
    localparam int BXE_DATA_W = 8;
    localparam int BXE_ADDR_W = 21;
    localparam int BXE_REG_AW = 3;

    // Register offsets; the address bytes follow the count, then the start register
    localparam int OFS_CNT_LO   = 0;
    localparam int OFS_CNT_HI   = 1;
    localparam int OFS_ADDR_B0  = 2;

    typedef enum logic {
        DIR_TO_BUF  = 1'b0,
        DIR_TO_HOST = 1'b1
    } bxe_dir_e;
endpackage

// File: rtl/bxe_cpu_decode.sv
// Module: decodes CPU register writes into load strobes.
// Assumes every load is blocked while a transfer is busy.
module bxe_cpu_decode
    import bxe_pkg::*;
#(
    parameter int REG_AW  = BXE_REG_AW,
    parameter int ADDR_NB = 3
) (
    input  logic              cpu_wr,
    input  logic [REG_AW-1:0] cpu_addr,
    input  logic              busy,
    output logic              ld_cnt_lo,
    output logic              ld_cnt_hi,
    output logic [ADDR_NB-1:0] ld_addr,
    output logic              trig
);
    localparam int OFS_TRIG = OFS_ADDR_B0 + ADDR_NB;

    logic wr_ok;
    assign wr_ok     = cpu_wr && !busy;
    assign ld_cnt_lo = wr_ok && (cpu_addr == REG_AW'(OFS_CNT_LO));
    assign ld_cnt_hi = wr_ok && (cpu_addr == REG_AW'(OFS_CNT_HI));
    assign trig      = wr_ok && (cpu_addr == REG_AW'(OFS_TRIG));

    // One load strobe per address byte lane
    for (genvar b = 0; b < ADDR_NB; b++) begin : g_addr_ld
        assign ld_addr[b] = wr_ok && (cpu_addr == REG_AW'(OFS_ADDR_B0 + b));
    end
endmodule

// File: rtl/bxe_byte_counter.sv
// Module: the transfer byte count, loaded bytewise and decremented by one.
// Assumes the count is two data bytes. In narrow mode the top bit is neither
// stored nor counted.
module bxe_byte_counter
    import bxe_pkg::*;
#(
    parameter int DATA_W = BXE_DATA_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  narrow,
    input  logic                  ld_lo,
    input  logic                  ld_hi,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  dec,
    output logic [2*DATA_W-1:0]   cnt,
    output logic                  is_zero,
    output logic                  is_one
);
    localparam int CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  eff;
    logic [DATA_W-1:0] hi_mask;

    assign hi_mask = {~narrow, {(DATA_W-1){1'b1}}};
    assign eff     = narrow ? {1'b0, cnt_q[CNT_W-2:0]} : cnt_q;
    assign is_zero = (eff == '0);
    assign is_one  = (eff == CNT_W'(1));
    assign cnt     = cnt_q;

    // Load bytes from the CPU, or count down once per accepted byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (dec) begin
            cnt_q <= eff - CNT_W'(1);
        end else begin
            if (ld_lo) cnt_q[DATA_W-1:0]     <= wdata;
            if (ld_hi) cnt_q[CNT_W-1:DATA_W] <= wdata & hi_mask;
        end
    end
endmodule

// File: rtl/bxe_addr_ptr.sv
// Module: the buffer address pointer, loaded bytewise and incremented per byte.
// Assumes the increment wraps modulo 2^ADDR_W and that loads and increments
// never arrive in the same cycle.
module bxe_addr_ptr
    import bxe_pkg::*;
#(
    parameter int DATA_W  = BXE_DATA_W,
    parameter int ADDR_W  = BXE_ADDR_W,
    parameter int ADDR_NB = (ADDR_W + DATA_W - 1) / DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_NB-1:0] ld,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               adv,
    output logic [ADDR_W-1:0]  addr
);
    localparam int PAD_W = ADDR_NB * DATA_W;

    logic [ADDR_W-1:0] ptr_q;
    logic [PAD_W-1:0]  pad;

    // Merge the byte-lane loads into a padded copy of the pointer
    always_comb begin
        pad = PAD_W'(ptr_q);
        for (int b = 0; b < ADDR_NB; b++) begin
            if (ld[b]) pad[b*DATA_W +: DATA_W] = wdata;
        end
    end

    // Advance on buffer-side bytes, otherwise take the CPU loads
    always_ff @(posedge clk) begin
        if (!rst_n)   ptr_q <= '0;
        else if (adv) ptr_q <= ptr_q + ADDR_W'(1);
        else          ptr_q <= pad[ADDR_W-1:0];
    end

    assign addr = ptr_q;
endmodule

// File: rtl/bxe_xfer_ctrl.sv
// Module: transfer control. It holds busy and the direction, picks the count
// strobe for the direction and raises the one-cycle end event.
// Assumes the start strobe arrives only while idle.
module bxe_xfer_ctrl
    import bxe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic dir_in,
    input  logic cnt_zero,
    input  logic cnt_one,
    input  logic host_rd_stb,
    input  logic buf_stb,
    output logic busy,
    output logic xfer_end,
    output logic dec,
    output logic adv
);
    logic     busy_q, end_q;
    bxe_dir_e dir_q;
    logic     last;

    assign dec  = busy_q && ((dir_q == DIR_TO_HOST) ? host_rd_stb : buf_stb);
    assign adv  = busy_q && buf_stb;
    assign last = dec && cnt_one;

    // Busy and end event: start on a nonzero count, stop on the last byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            end_q  <= 1'b0;
        end else if (busy_q) begin
            busy_q <= !last;
            end_q  <= last;
        end else begin
            busy_q <= trig && !cnt_zero;
            end_q  <= trig && cnt_zero;
        end
    end

    // Latch the direction when a transfer is started
    always_ff @(posedge clk) begin
        if (!rst_n)    dir_q <= DIR_TO_BUF;
        else if (trig) dir_q <= bxe_dir_e'(dir_in);
    end

    assign busy     = busy_q;
    assign xfer_end = end_q;
endmodule

// File: rtl/bufxfer_engine.sv
// Module: top of the buffer transfer counting and addressing engine.
// Assumes single-cycle strobes from the host port and the memory side, and
// CPU writes that are decoded to register offsets.
module bufxfer_engine
    import bxe_pkg::*;
#(
    parameter int DATA_W = BXE_DATA_W,
    parameter int ADDR_W = BXE_ADDR_W,
    parameter int REG_AW = BXE_REG_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              narrow_cnt,
    input  logic              cpu_wr,
    input  logic [REG_AW-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              xfer_end_irq,
    input  logic              host_rd_stb,
    input  logic              buf_stb,
    output logic              busy,
    output logic              xfer_end,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [DATA_W-1:0] cnt_rd_lo,
    output logic [DATA_W-1:0] cnt_rd_hi
);
    localparam int ADDR_NB = (ADDR_W + DATA_W - 1) / DATA_W;
    localparam int CNT_W   = 2 * DATA_W;

    logic               ld_cnt_lo, ld_cnt_hi, trig_ok;
    logic [ADDR_NB-1:0] ld_addr;
    logic [CNT_W-1:0]   cnt_q;
    logic               cnt_zero, cnt_one, cnt_dec, addr_adv;

    bxe_cpu_decode #(.REG_AW(REG_AW), .ADDR_NB(ADDR_NB)) u_dec (
        .cpu_wr    (cpu_wr),
        .cpu_addr  (cpu_addr),
        .busy      (busy),
        .ld_cnt_lo (ld_cnt_lo),
        .ld_cnt_hi (ld_cnt_hi),
        .ld_addr   (ld_addr),
        .trig      (trig_ok)
    );

    bxe_byte_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .narrow  (narrow_cnt),
        .ld_lo   (ld_cnt_lo),
        .ld_hi   (ld_cnt_hi),
        .wdata   (cpu_wdata),
        .dec     (cnt_dec),
        .cnt     (cnt_q),
        .is_zero (cnt_zero),
        .is_one  (cnt_one)
    );

    bxe_addr_ptr #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ADDR_NB(ADDR_NB)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (ld_addr),
        .wdata (cpu_wdata),
        .adv   (addr_adv),
        .addr  (buf_addr)
    );

    bxe_xfer_ctrl u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig        (trig_ok),
        .dir_in      (cpu_wdata[0]),
        .cnt_zero    (cnt_zero),
        .cnt_one     (cnt_one),
        .host_rd_stb (host_rd_stb),
        .buf_stb     (buf_stb),
        .busy        (busy),
        .xfer_end    (xfer_end),
        .dec         (cnt_dec),
        .adv         (addr_adv)
    );

    // Count readback; in narrow mode the top bit shows the interrupt flag
    assign cnt_rd_lo = cnt_q[DATA_W-1:0];
    assign cnt_rd_hi = narrow_cnt ? {xfer_end_irq, cnt_q[CNT_W-2:DATA_W]}
                                  : cnt_q[CNT_W-1:DATA_W];
endmodule

// File: rtl/bufxfer_engine_chk.sv
// Module: assertion checker, bound to the top of the transfer engine.
module bufxfer_engine_chk #(
    parameter int ADDR_W = 21,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              xfer_end,
    input logic              buf_stb,
    input logic              cpu_wr,
    input logic              trig,
    input logic              cnt_zero,
    input logic              dec,
    input logic [ADDR_W-1:0] buf_addr,
    input logic [CNT_W-1:0]  cnt
);
    // R9
    end_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_end |=> !xfer_end);

    // R9
    busy_fall_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> xfer_end);

    // R8
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && buf_stb) |=> (buf_addr == $past(buf_addr) + ADDR_W'(1)));

    // R12
    idle_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cpu_wr) |=> $stable(buf_addr));

    // R6
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec |=> (cnt[CNT_W-2:0] == $past(cnt[CNT_W-2:0]) - (CNT_W-1)'(1)));

    // R5
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !cnt_zero) |=> busy);

    // R10
    zero_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && cnt_zero) |=> (xfer_end && !busy));
endmodule

bind bufxfer_engine bufxfer_engine_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .xfer_end (xfer_end),
    .buf_stb  (buf_stb),
    .cpu_wr   (cpu_wr),
    .trig     (trig_ok),
    .cnt_zero (cnt_zero),
    .dec      (cnt_dec),
    .buf_addr (buf_addr),
    .cnt      (cnt_q)
);

// File: tb/bufxfer_engine_tb_top.sv
module bufxfer_engine_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        narrow_cnt = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [2:0]  cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        xfer_end_irq = 1'b0;
    logic        host_rd_stb = 1'b0;
    logic        buf_stb = 1'b0;
    logic        busy, xfer_end;
    logic [20:0] buf_addr;
    logic [7:0]  cnt_rd_lo, cnt_rd_hi;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bufxfer_engine dut_i (
        .clk(clk), .rst_n(rst_n), .narrow_cnt(narrow_cnt), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .xfer_end_irq(xfer_end_irq),
        .host_rd_stb(host_rd_stb), .buf_stb(buf_stb), .busy(busy),
        .xfer_end(xfer_end), .buf_addr(buf_addr), .cnt_rd_lo(cnt_rd_lo),
        .cnt_rd_hi(cnt_rd_hi)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic strobe(input logic h, input logic b);
        @(negedge clk);
        host_rd_stb = h; buf_stb = b;
        @(negedge clk);
        host_rd_stb = 1'b0; buf_stb = 1'b0;
    endtask

    task automatic load(input logic [15:0] c, input logic [20:0] a);
        wr(3'd0, c[7:0]);
        wr(3'd1, c[15:8]);
        wr(3'd2, a[7:0]);
        wr(3'd3, a[15:8]);
        wr(3'd4, {3'b000, a[20:16]});
    endtask

    task automatic t_reset;
        chk("R1 busy", busy, 0);
        chk("R1 end", xfer_end, 0);
        chk("R1 cnt", {cnt_rd_hi, cnt_rd_lo}, 0);
        chk("R1 addr", buf_addr, 0);
    endtask

    task automatic t_load_wide;
        narrow_cnt = 1'b0;
        wr(3'd0, 8'h34);
        wr(3'd1, 8'hB2);
        chk("R4 R2 cnt readback", {cnt_rd_hi, cnt_rd_lo}, 32'hB234);
        wr(3'd2, 8'h56); wr(3'd3, 8'h34); wr(3'd4, 8'hF2);
        chk("R2 addr load", buf_addr, 32'h123456);
    endtask

    task automatic t_narrow;
        narrow_cnt = 1'b1;
        wr(3'd1, 8'hB2);
        xfer_end_irq = 1'b1;
        #1 chk("R3 irq shown in bit7", cnt_rd_hi, 8'hB2);
        xfer_end_irq = 1'b0;
        #1 chk("R3 bit7 not stored", cnt_rd_hi, 8'h32);
        narrow_cnt = 1'b0;
        #1 chk("R3 bit15 dropped", cnt_rd_hi, 8'h32);
    endtask

    task automatic t_to_host;
        narrow_cnt = 1'b0;
        load(16'd3, 21'h000100);
        wr(3'd5, 8'h01);
        chk("R5 busy", busy, 1);
        strobe(1'b0, 1'b1);
        strobe(1'b0, 1'b1);
        chk("R8 addr", buf_addr, 32'h102);
        chk("R6 buf strobe no count", cnt_rd_lo, 3);
        strobe(1'b1, 1'b0);
        chk("R6 host read dec", cnt_rd_lo, 2);
        chk("R8 host read no addr", buf_addr, 32'h102);
        strobe(1'b1, 1'b1);
        chk("R6 same-cycle dec", cnt_rd_lo, 1);
        chk("R8 same-cycle inc", buf_addr, 32'h103);
        wr(3'd0, 8'h77);
        wr(3'd2, 8'h00);
        chk("R12 busy cnt write ignored", cnt_rd_lo, 1);
        chk("R12 busy addr write ignored", buf_addr, 32'h103);
        strobe(1'b1, 1'b0);
        chk("R9 busy clear", busy, 0);
        chk("R9 end pulse", xfer_end, 1);
        chk("R9 cnt zero", {cnt_rd_hi, cnt_rd_lo}, 0);
        @(negedge clk);
        chk("R9 end one cycle", xfer_end, 0);
        strobe(1'b1, 1'b1);
        chk("R12 idle strobe addr", buf_addr, 32'h103);
        chk("R12 idle strobe cnt", cnt_rd_lo, 0);
    endtask

    task automatic t_to_buf;
        load(16'd2, 21'h1FFFFF);
        wr(3'd5, 8'h00);
        chk("R5 busy h2m", busy, 1);
        strobe(1'b1, 1'b0);
        chk("R7 host read no count", cnt_rd_lo, 2);
        strobe(1'b0, 1'b1);
        chk("R7 buf write dec", cnt_rd_lo, 1);
        chk("R11 addr wrap", buf_addr, 0);
        strobe(1'b0, 1'b1);
        chk("R9 end h2m", {busy, xfer_end}, 32'b01);
        chk("R8 addr after wrap", buf_addr, 1);
    endtask

    task automatic t_zero;
        load(16'd0, 21'h0ABCDE);
        wr(3'd5, 8'h01);
        chk("R10 end", xfer_end, 1);
        chk("R10 no busy", busy, 0);
        chk("R10 addr kept", buf_addr, 32'h0ABCDE);
        @(negedge clk);
        chk("R10 end one cycle", xfer_end, 0);
        narrow_cnt = 1'b1;
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h80);
        wr(3'd5, 8'h01);
        chk("R3 0x8000 is zero narrow", {busy, xfer_end}, 32'b01);
        narrow_cnt = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load_wide();
        t_narrow();
        t_to_host();
        t_to_buf();
        t_zero();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule